// File: doc/BRIEF.md
# Receive FIFO DMA Request Controller

This block sits beside the receive FIFO of an Ethernet MAC and decides when the host bus engine should be asked to move received data. The MAC marks each byte it writes into the FIFO, flags the last byte of every frame, and says whether that frame finished cleanly. The FIFO reports its current fill level in bytes. From these inputs the block counts the bytes of the frame in progress and raises `dma_req` only when the frame can no longer be a runt or a slot-time collision fragment, and only when the FIFO holds enough data to make a transfer worthwhile.

The fill threshold comes from a 2-bit watermark field. The field is written and read through a small register port that works only while the `stop` qualifier is high. A runt-accept enable relaxes the 64-byte gate. With it set, the watermark alone can start a request, and so can a short frame that completed cleanly. A frame that ends in error before it earns a request is discarded, and the per-frame count starts again from zero. After a frame completes cleanly, the request stays up until the FIFO has emptied. The MAC is expected to start no new frame while that drain is in progress.

The controller is a four-state machine. **IDLE** means no frame is in progress. **COLLECT** means a frame is arriving with the request off. **STREAM** means the request is on while the frame is still arriving. **DRAIN** means a valid frame has ended and the request stays on until the FIFO is empty. The transitions are:
- IDLE→COLLECT on the first byte of a frame.
- IDLE→DRAIN when a one-byte frame completes and qualifies.
- COLLECT→STREAM when the gate is open and the level is at or above the threshold. The gate is open once 64 bytes are counted, or when runt accept is set.
- COLLECT→DRAIN when a frame ends valid with 64 or more bytes, or ends valid with runt accept set.
- COLLECT→IDLE when a frame ends in any other way.
- STREAM→COLLECT when the level falls below the threshold.
- STREAM→DRAIN when the frame ends valid.
- STREAM→IDLE when the frame ends with an error.
- DRAIN→IDLE when the level reaches zero.

Top module: `rxdma_req_ctrl`

## Requirements
- R1: After a hardware reset (`rst_n` low) or a one-cycle software reset (`soft_rst` high), the watermark field holds code 10, `dma_req` is low and the frame count is zero.
- R2: The watermark codes select these fill thresholds: code 00 selects 16 bytes, code 01 selects 32 bytes and code 10 selects 64 bytes.
- R3: A write through `cfg_wr_en`/`cfg_wr_data` updates the field only when `stop` is high. `cfg_rd_data` returns the field while `stop` is high and returns 00 while `stop` is low.
- R4: With runt accept off, `dma_req` stays low for a frame until 64 bytes of that frame have been counted, whatever the FIFO level.
- R5: When the frame count is at 64 and `fifo_level` is at or above the threshold at a clock edge, `dma_req` is high from that edge onward.
- R6: With `runt_accept` high, the threshold alone starts the request. A frame that ends with `frame_ok` high also starts the request, whatever its length.
- R7: A frame that ends with `frame_ok` low drops `dma_req` at the next edge unless the machine is draining. The frame count also returns to zero after every frame end.
- R8: A write of the reserved code 11 is ignored, and the field keeps its previous code.
- R9: While a frame is still arriving, `dma_req` falls one edge after `fifo_level` drops below the threshold.
- R10: After a valid frame end has raised or kept `dma_req`, the request stays high until `fifo_level` reads zero at an edge, and then falls.
- R11: Changing `stop` by itself never changes the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset, synchronous, active high |
| stop | input | 1 | Qualifier that opens the watermark field to writes and reads |
| cfg_wr_en | input | 1 | Watermark write strobe |
| cfg_wr_data | input | 2 | Watermark code to write |
| cfg_rd_data | output | 2 | Watermark readback (00 while `stop` is low) |
| runt_accept | input | 1 | Accept short frames and drop the 64-byte gate |
| byte_in | input | 1 | One byte of the current frame enters the FIFO this cycle |
| frame_end | input | 1 | Last byte or end marker of the current frame |
| frame_ok | input | 1 | Frame completed without error (valid with `frame_end`) |
| fifo_level | input | LVL_W | Bytes currently held in the receive FIFO |
| dma_req | output | 1 | Receive DMA request |

## Verification
The request logic is tried with several frame patterns. A short valid frame placed under a low watermark separates the 64-byte gate from the threshold test. A long frame that is stalled and then partly drained separates the threshold hold from the end-of-frame hold. A bad frame followed by a short frame exposes a frame count that fails to clear. The same short frames are then repeated with runt accept set, which shows the threshold start apart from the completion start. The register port is exercised with writes while `stop` is low, writes of the reserved code and soft resets, so that the gating of writes and readback can be told apart from the reset value.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_STREAM  = 2'd2,
        ST_DRAIN   = 2'd3
    } rx_state_e;

    localparam logic [1:0] WM_CODE_RESET = 2'b10;
    localparam logic [1:0] WM_CODE_RSVD  = 2'b11;

endpackage

// File: rtl/rxdma_wmark_reg.sv
module rxdma_wmark_reg
    import rxdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       stop,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] field
);

    logic wr_take;

    assign wr_take = stop && wr_en && (wr_data != WM_CODE_RSVD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field <= WM_CODE_RESET;
        end else if (soft_rst) begin
            field <= WM_CODE_RESET;
        end else if (wr_take) begin
            field <= wr_data;
        end
    end

    // R3 / R11: a closed port leaves the field alone
    a_r3_closed_port_holds: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !stop |=> $stable(field));

    // R8: reserved code never lands
    a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wr_en && wr_data == WM_CODE_RSVD) |=> $stable(field));

    // R8: field never holds the reserved code
    a_r8_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        field != WM_CODE_RSVD);

endmodule

// File: rtl/rxdma_frame_cnt.sv
module rxdma_frame_cnt #(
    parameter int MIN_BYTES = 64,
    localparam int CNT_W    = $clog2(MIN_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic byte_in,
    input  logic frame_end,
    output logic min_met,
    output logic total_met
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_plus;

    assign cnt_plus  = {1'b0, cnt} + {{CNT_W{1'b0}}, byte_in};
    assign min_met   = (cnt >= CNT_W'(MIN_BYTES));
    assign total_met = (cnt_plus >= (CNT_W+1)'(MIN_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (soft_rst || frame_end) begin
            cnt <= '0;
        end else if (byte_in && !min_met) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: count saturates at the runt limit
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MIN_BYTES));

    // R7: every frame end restarts the count
    a_r7_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (cnt == '0));

endmodule

// File: rtl/rxdma_req_fsm.sv
module rxdma_req_fsm
    import rxdma_pkg::*;
#(
    parameter int LVL_W   = 8,
    parameter int WM_BASE = 16,
    localparam int THR_W  = $clog2(WM_BASE * 4 + 1),
    localparam int CMP_W  = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [1:0]       wm_code,
    input  logic             runt_accept,
    input  logic             byte_in,
    input  logic             frame_end,
    input  logic             frame_ok,
    input  logic             min_met,
    input  logic             total_met,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             dma_req
);

    rx_state_e state, state_nx;

    logic [CMP_W-1:0] lvl_ext;
    logic [CMP_W-1:0] thr_ext;
    logic             at_thr;
    logic             gate_open;
    logic             end_accept;
    logic             fifo_empty;

    assign lvl_ext    = CMP_W'(fifo_level);
    assign thr_ext    = CMP_W'(WM_BASE) << wm_code;
    assign at_thr     = (lvl_ext >= thr_ext);
    assign gate_open  = min_met || runt_accept;
    assign end_accept = frame_ok && (total_met || runt_accept);
    assign fifo_empty = (fifo_level == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (byte_in && frame_end) begin
                    state_nx = end_accept ? ST_DRAIN : ST_IDLE;
                end else if (byte_in) begin
                    state_nx = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (frame_end) begin
                    state_nx = end_accept ? ST_DRAIN : ST_IDLE;
                end else if (gate_open && at_thr) begin
                    state_nx = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (frame_end) begin
                    state_nx = frame_ok ? ST_DRAIN : ST_IDLE;
                end else if (!at_thr) begin
                    state_nx = ST_COLLECT;
                end
            end
            ST_DRAIN: begin
                if (fifo_empty) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (soft_rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        dma_req = 1'b0;
        unique case (state)
            ST_IDLE:    dma_req = 1'b0;
            ST_COLLECT: dma_req = 1'b0;
            ST_STREAM:  dma_req = 1'b1;
            ST_DRAIN:   dma_req = 1'b1;
        endcase
    end

    // R4 / R6: streaming begins only through an open gate
    a_r4_gate_before_stream: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && $past(state) == ST_COLLECT) |-> $past(min_met || runt_accept));

    // R7: an errored end drops the request
    a_r7_bad_end_drops: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (frame_end && !frame_ok && state != ST_DRAIN) |=> !dma_req);

    // R10: an empty FIFO ends the drain
    a_r10_drain_exit: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (state == ST_DRAIN && fifo_empty) |=> (state == ST_IDLE));

    // R10: drain holds while data remains
    a_r10_drain_holds: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (state == ST_DRAIN && !fifo_empty) |=> dma_req);

endmodule

// File: rtl/rxdma_req_ctrl.sv
module rxdma_req_ctrl #(
    parameter int LVL_W     = 8,
    parameter int MIN_BYTES = 64,
    parameter int WM_BASE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_data,
    output logic [1:0]       cfg_rd_data,
    input  logic             runt_accept,
    input  logic             byte_in,
    input  logic             frame_end,
    input  logic             frame_ok,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             dma_req
);

    logic [1:0] wm_code;
    logic       min_met;
    logic       total_met;

    rxdma_wmark_reg u_wmark (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .stop     (stop),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .field    (wm_code)
    );

    rxdma_frame_cnt #(
        .MIN_BYTES (MIN_BYTES)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .byte_in   (byte_in),
        .frame_end (frame_end),
        .min_met   (min_met),
        .total_met (total_met)
    );

    rxdma_req_fsm #(
        .LVL_W   (LVL_W),
        .WM_BASE (WM_BASE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .wm_code     (wm_code),
        .runt_accept (runt_accept),
        .byte_in     (byte_in),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok),
        .min_met     (min_met),
        .total_met   (total_met),
        .fifo_level  (fifo_level),
        .dma_req     (dma_req)
    );

    assign cfg_rd_data = stop ? wm_code : 2'b00;

    // R3: readback is silent while the port is closed
    a_r3_closed_readback: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |-> (cfg_rd_data == 2'b00));

endmodule

// File: tb/test_rxdma_req_ctrl.sv
module test_rxdma_req_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stop = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_data = 2'b00;
    logic [1:0] cfg_rd_data;
    logic       runt_accept = 1'b0;
    logic       byte_in = 1'b0;
    logic       frame_end = 1'b0;
    logic       frame_ok = 1'b0;
    logic [7:0] fifo_level = 8'd0;
    logic       dma_req;

    int checks = 0;
    int fails = 0;
    int lvl = 0;
    bit seen_req = 0;

    int m_ph = 0;
    int m_cnt = 0;
    int m_wm = 2;

    always #4 clk = ~clk;

    rxdma_req_ctrl i_rxdma_req_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .runt_accept(runt_accept), .byte_in(byte_in), .frame_end(frame_end),
        .frame_ok(frame_ok), .fifo_level(fifo_level), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated at each edge from pre-edge inputs
    always @(posedge clk) begin
        int tot, thr, lv;
        bit gate, good_end;
        if (!rst_n || soft_rst) begin
            m_ph = 0; m_cnt = 0; m_wm = 2;
        end else begin
            tot = m_cnt + int'(byte_in);
            thr = 16 * (1 << m_wm);
            lv = int'(fifo_level);
            gate = (m_cnt >= 64) || runt_accept;
            good_end = frame_ok && (runt_accept || tot >= 64);
            case (m_ph)
                0: if (byte_in && frame_end) m_ph = good_end ? 3 : 0;
                   else if (byte_in) m_ph = 1;
                1: if (frame_end) m_ph = good_end ? 3 : 0;
                   else if (gate && lv >= thr) m_ph = 2;
                2: if (frame_end) m_ph = frame_ok ? 3 : 0;
                   else if (lv < thr) m_ph = 1;
                default: if (lv == 0) m_ph = 0;
            endcase
            if (frame_end) m_cnt = 0;
            else if (byte_in && m_cnt < 64) m_cnt = m_cnt + 1;
            if (stop && cfg_wr_en && cfg_wr_data != 2'b11) m_wm = int'(cfg_wr_data);
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 req vs model", int'(dma_req), (m_ph >= 2) ? 1 : 0);
            chk("R3 readback vs model", int'(cfg_rd_data), stop ? m_wm : 0);
            if (dma_req) seen_req = 1;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] code);
        cfg_wr_en = 1'b1; cfg_wr_data = code; tick();
        cfg_wr_en = 1'b0; tick();
    endtask

    task automatic push(input int n, input bit fin, input bit ok);
        for (int i = 0; i < n; i++) begin
            fifo_level = 8'(lvl);
            byte_in = 1'b1;
            frame_end = fin && (i == n - 1);
            frame_ok = ok;
            tick();
            lvl++;
        end
        byte_in = 1'b0; frame_end = 1'b0; frame_ok = 1'b0;
        fifo_level = 8'(lvl);
    endtask

    task automatic pop(input int n);
        for (int i = 0; i < n; i++) begin
            lvl--;
            fifo_level = 8'(lvl);
            tick();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        tick();
        #3;
        // R1 reset state
        chk("R1 reset field", int'(cfg_rd_data), 2);
        chk("R1 reset req", int'(dma_req), 0);

        // R3 writes blocked while stop low, readback zero
        stop = 1'b0; wr(2'b00);
        #3 chk("R3 readback closed", int'(cfg_rd_data), 0);
        stop = 1'b1; tick();
        #3 chk("R3 write ignored while closed", int'(cfg_rd_data), 2);
        // R11 toggling stop alone
        stop = 1'b0; idle(2); stop = 1'b1; tick();
        #3 chk("R11 stop toggle keeps field", int'(cfg_rd_data), 2);

        // R8 reserved code, R2 code mapping via readback
        wr(2'b01); wr(2'b11);
        #3 chk("R8 reserved write ignored", int'(cfg_rd_data), 1);
        wr(2'b00);
        #3 chk("R2 code 00 stored", int'(cfg_rd_data), 0);

        // R4: 40-byte valid frame, threshold 16, runt off
        seen_req = 0;
        push(40, 1, 1); idle(3);
        chk("R4 short frame no request", int'(seen_req), 0);
        pop(40); idle(2);

        // R5 / R10: long frame, threshold 16
        push(63, 0, 0); idle(2);
        chk("R4 no request at 63 bytes", int'(dma_req), 0);
        push(7, 0, 0); idle(2);
        chk("R5 request after 64 bytes", int'(dma_req), 1);
        push(1, 1, 1); idle(2);
        chk("R10 request held after end", int'(dma_req), 1);
        pop(70);
        #3 chk("R10 request held one byte left", int'(dma_req), 1);
        pop(1); idle(2);
        chk("R10 request drops when empty", int'(dma_req), 0);

        // R9 / R7: threshold 32, level falls, then bad end
        wr(2'b01);
        push(70, 0, 0); idle(2);
        chk("R2 request at threshold 32", int'(dma_req), 1);
        pop(50); idle(2);
        chk("R9 request falls below threshold", int'(dma_req), 0);
        pop(0);
        push(20, 0, 0); idle(2);
        chk("R9 request returns at threshold", int'(dma_req), 1);
        push(1, 1, 0); idle(1);
        chk("R7 bad end drops request", int'(dma_req), 0);
        pop(lvl); idle(2);

        // R7: count clears between frames (threshold 16)
        wr(2'b00);
        push(50, 1, 0); pop(50); idle(2);
        seen_req = 0;
        push(30, 1, 1); idle(3);
        chk("R7 count restarted", int'(seen_req), 0);
        pop(30); idle(2);

        // R6: runt accept, threshold starts request
        runt_accept = 1'b1;
        push(20, 0, 0); idle(2);
        chk("R6 threshold without 64 bytes", int'(dma_req), 1);
        push(1, 1, 1); pop(21); idle(2);
        chk("R6 drained", int'(dma_req), 0);

        // R2: threshold 32 under runt accept
        wr(2'b01);
        push(31, 0, 0); idle(2);
        chk("R2 below 32 no request", int'(dma_req), 0);
        push(1, 0, 0); idle(2);
        chk("R2 at 32 request", int'(dma_req), 1);
        push(1, 1, 0); idle(1);
        chk("R7 bad end under runt accept", int'(dma_req), 0);
        pop(lvl); idle(2);

        // R6: short complete frame at threshold 64
        wr(2'b10);
        push(10, 1, 1); idle(1);
        chk("R6 short valid frame requests", int'(dma_req), 1);
        pop(10); idle(2);
        chk("R6 short frame drained", int'(dma_req), 0);
        seen_req = 0;
        push(10, 1, 0); idle(3);
        chk("R7 short bad frame no request", int'(seen_req), 0);
        pop(10);
        runt_accept = 1'b0;
        idle(2);

        // R1 soft reset mid-frame and field restore
        wr(2'b00);
        push(70, 0, 0); idle(2);
        chk("R5 request before soft reset", int'(dma_req), 1);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        #3 chk("R1 soft reset drops request", int'(dma_req), 0);
        chk("R1 soft reset field", int'(cfg_rd_data), 2);
        fifo_level = 8'd0; lvl = 0;
        idle(3);

        summary();
    end

endmodule